// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave

This block is a serial memory target reached over a four-wire SPI port: active-low select, serial clock, data in and data out. Behind the port sits a byte-addressed array of `2**ADDR_W` bytes, split into 64-byte pages. Setting `ADDR_W` to 15 gives the full 32 KiB arrangement. The default build is smaller so that the array stays modest. Every SPI line is synchronised into the system clock domain and its edges are detected there. The SPI clock must therefore run several times slower than `clk`.

A host issues one-byte commands to read, fast-read, program, erase a page, erase the whole array, set the write-enable latch, and read the status byte. Incoming program bytes are collected in a page buffer. When select rises, a commit engine writes only the buffered bytes into the array. A busy timer then holds the block unavailable for a time that grows with the number of bytes. Erase commands use the same engine to fill a page or the whole array with 0xFF.

The control state machine has these states. ST_CMD waits for an opcode. ST_ADDR_HI and ST_ADDR_LO take the address. ST_DUMMY absorbs the fast-read filler byte. ST_READ streams data. ST_PROG collects program data. ST_ERASE_ARM waits for select to rise on an erase. ST_STATUS streams the status byte. ST_IGNORE discards the rest of the transaction.

The transitions are as follows. Deselect goes from any state to ST_CMD. From ST_CMD, a status opcode leads to ST_STATUS. Read, fast-read, and program or page erase with the latch set lead to ST_ADDR_HI. Chip erase with the latch set leads to ST_ERASE_ARM. Write-enable, any other opcode, and anything arriving while busy lead to ST_IGNORE. ST_ADDR_HI leads to ST_ADDR_LO. ST_ADDR_LO leads to ST_READ, ST_DUMMY, ST_PROG or ST_ERASE_ARM, depending on the command. ST_DUMMY leads to ST_READ. The remaining states hold until deselect.

Top module: `spi_mem_slave`

## Requirements
- R1: SPI modes 0 and 3 both work. Data in is sampled on rising serial-clock edges and data out changes on falling edges, most significant bit first.
- R2: Opcode 0x03 is followed by an address high byte and low byte. After the low byte, it returns successive bytes from incrementing addresses, wrapping from the top address to 0. Address bits above `ADDR_W` are ignored.
- R3: Opcode 0x0B behaves as 0x03, except that one dummy byte follows the address before data starts.
- R4: Opcode 0x02 is followed by a two-byte address and 1 to 64 data bytes. It changes only the bytes received and leaves the rest of the page unchanged.
- R5: During a program, the write offset wraps to the start of the same 64-byte page. A later byte at the same offset replaces an earlier one.
- R6: Opcode 0x42 is followed by an address and sets every byte of the addressed page to 0xFF. Other pages are untouched.
- R7: Opcode 0x60 sets every byte of the array to 0xFF.
- R8: Opcode 0x05 returns the status byte repeatedly. Bit 0 is busy, bit 1 is the write-enable latch, and the other bits are 0.
- R9: Program and erase take effect only if opcode 0x06 has set the latch. The latch clears when the operation completes.
- R10: Busy lasts at least PROG_BASE_CYC + PROG_BYTE_CYC × n cycles after a program of n bytes (n capped at 64). While busy, every opcode except 0x05 is ignored, including 0x06.
- R11: Raising select in the middle of a byte aborts the command. Nothing is committed and the latch stays set.
- R12: An undefined opcode is ignored and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI serial clock, idle low or high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 when deselected |

## Verification
The bench builds the block with `ADDR_W` = 10, which makes 16 pages. With this size the top-to-zero read wrap, chip erase and wrap within a page are all reachable in a short run. The timing parameters are a 150-cycle program base, 40 cycles per byte, 600 cycles for a page erase and 1200 for a chip erase. With these values the byte-count scaling of busy time can be measured by status polling against a bench model. Random programs in both SPI modes, with random upper address bits, are compared byte for byte with that model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int PAGE_W     = 6;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FAST   = 8'h0B;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_PERASE = 8'h42;
    localparam logic [7:0] OP_CERASE = 8'h60;

    typedef enum logic [1:0] {
        JOB_PROG,
        JOB_PERASE,
        JOB_CERASE
    } job_t;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DUMMY,
        ST_READ,
        ST_PROG,
        ST_ERASE_ARM,
        ST_STATUS,
        ST_IGNORE
    } st_t;

endpackage

// File: rtl/spi_mem_link.sv
module spi_mem_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    output logic       sel,
    output logic       byte_stb,
    output logic [7:0] rx_byte,
    output logic       cs_rise,
    output logic       on_boundary
);

    logic [SYNC_STAGES:0]   sck_h;
    logic [SYNC_STAGES:0]   cs_h;
    logic [SYNC_STAGES-1:0] mosi_h;
    logic sck_s, sck_q, cs_s, cs_q, mosi_s;
    logic sck_rise, sck_fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_h  <= '0;
            cs_h   <= '1;
            mosi_h <= '0;
        end else begin
            sck_h  <= {sck_h[SYNC_STAGES-1:0], sck};
            cs_h   <= {cs_h[SYNC_STAGES-1:0], cs_n};
            mosi_h <= {mosi_h[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sck_s    = sck_h[SYNC_STAGES-1];
    assign sck_q    = sck_h[SYNC_STAGES];
    assign cs_s     = cs_h[SYNC_STAGES-1];
    assign cs_q     = cs_h[SYNC_STAGES];
    assign mosi_s   = mosi_h[SYNC_STAGES-1];
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign sel      = ~cs_s;
    assign cs_rise  = cs_s & ~cs_q;
    assign on_boundary = (bit_cnt == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            byte_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    rx_byte  <= {rx_sh[6:0], mosi_s};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (!sel) begin
            miso_q <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_data;
        end else if (sck_fall) begin
            miso_q <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
        end
    end

    assign miso = sel & miso_q;

endmodule

// File: rtl/spi_mem_commit.sv
module spi_mem_commit
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int TIMER_W = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               buf_clr,
    input  logic               buf_we,
    input  logic [PAGE_W-1:0]  buf_off,
    input  logic [7:0]         buf_data,
    input  logic               start,
    input  job_t               job,
    input  logic [ADDR_W-1:0]  base,
    input  logic [TIMER_W-1:0] span,
    output logic               busy,
    output logic               done,
    output logic               chip_run,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata
);

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;
    logic                  active;
    logic [ADDR_W-1:0]     idx;
    logic [ADDR_W-1:0]     last_idx;
    job_t                  job_q;
    logic [ADDR_W-1:0]     base_q;
    logic [TIMER_W-1:0]    timer;
    logic [PAGE_W-1:0]     off;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_off] <= buf_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pval <= '0;
        else if (buf_clr) pval <= '0;
        else if (buf_we)  pval[buf_off] <= 1'b1;
    end

    assign last_idx = (job_q == JOB_CERASE) ? {ADDR_W{1'b1}} : ADDR_W'(PAGE_BYTES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            job_q  <= JOB_PROG;
            base_q <= '0;
            timer  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                timer  <= span;
                active <= 1'b1;
                idx    <= '0;
                job_q  <= job;
                base_q <= base;
                busy   <= 1'b1;
            end else begin
                if (timer != '0) timer <= timer - 1'b1;
                if (active) begin
                    idx <= idx + 1'b1;
                    if (idx == last_idx) active <= 1'b0;
                end
                if (busy && timer == '0 && !active) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign off       = idx[PAGE_W-1:0];
    assign chip_run  = (job_q == JOB_CERASE);
    assign mem_addr  = chip_run ? idx : {base_q[ADDR_W-1:PAGE_W], off};
    assign mem_we    = active && (job_q != JOB_PROG || pval[off]);
    assign mem_wdata = (job_q == JOB_PROG) ? pbuf[off] : 8'hFF;

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int TIMER_W        = 26,
    parameter int SYNC_STAGES    = 2,
    parameter int PROG_BASE_CYC  = 3333,
    parameter int PROG_BYTE_CYC  = 11667,
    parameter int PAGE_ERASE_CYC = 750000,
    parameter int CHIP_ERASE_CYC = 20000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);

    localparam int CNT_W = PAGE_W + 1;

    logic               sel, byte_stb, cs_rise, on_boundary;
    logic [7:0]         rx_byte;
    logic               tx_load;
    logic [7:0]         tx_data;
    logic               buf_clr, buf_we, start;
    job_t               job;
    logic [TIMER_W-1:0] span;
    logic               busy, done, chip_run;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [7:0]         mem_wdata;
    logic [ADDR_W-1:0]  rd_addr;
    logic [7:0]         rd_data;

    st_t                state, nxt;
    logic [7:0]         cmd_q;
    logic [7:0]         addr_hi;
    logic [ADDR_W-1:0]  ptr;
    logic [PAGE_W-1:0]  pg_off;
    logic [CNT_W-1:0]   pg_cnt;
    logic               wel;

    logic [15:0]        full_addr;
    logic [ADDR_W-1:0]  start_ptr;
    logic [7:0]         status;

    assign full_addr = {addr_hi, rx_byte};
    assign start_ptr = full_addr[ADDR_W-1:0];
    assign status    = {6'b0, wel, busy};
    assign rd_addr   = (state == ST_ADDR_LO) ? start_ptr : ptr;

    spi_mem_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .tx_load(tx_load), .tx_data(tx_data), .sel(sel),
        .byte_stb(byte_stb), .rx_byte(rx_byte), .cs_rise(cs_rise),
        .on_boundary(on_boundary)
    );

    spi_mem_commit #(.ADDR_W(ADDR_W), .TIMER_W(TIMER_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_off(pg_off), .buf_data(rx_byte), .start(start), .job(job),
        .base(ptr), .span(span), .busy(busy), .done(done),
        .chip_run(chip_run), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    spi_mem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= nxt;
    end

    // next state and control outputs
    always_comb begin
        nxt     = state;
        tx_load = 1'b0;
        tx_data = rd_data;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        start   = 1'b0;
        job     = JOB_PROG;
        span    = '0;
        if (!sel) begin
            nxt = ST_CMD;
            if (cs_rise && on_boundary) begin
                if (state == ST_PROG && pg_cnt != '0) begin
                    start = 1'b1;
                    job   = JOB_PROG;
                    span  = TIMER_W'(PROG_BASE_CYC)
                          + TIMER_W'(PROG_BYTE_CYC) * TIMER_W'(pg_cnt);
                end else if (state == ST_ERASE_ARM) begin
                    start = 1'b1;
                    if (cmd_q == OP_CERASE) begin
                        job  = JOB_CERASE;
                        span = TIMER_W'(CHIP_ERASE_CYC);
                    end else begin
                        job  = JOB_PERASE;
                        span = TIMER_W'(PAGE_ERASE_CYC);
                    end
                end
            end
        end else if (byte_stb) begin
            unique case (state)
                ST_CMD: begin
                    if (busy && rx_byte != OP_STATUS) begin
                        nxt = ST_IGNORE;
                    end else begin
                        case (rx_byte)
                            OP_STATUS: begin
                                tx_load = 1'b1;
                                tx_data = status;
                                nxt     = ST_STATUS;
                            end
                            OP_READ, OP_FAST:   nxt = ST_ADDR_HI;
                            OP_PROG, OP_PERASE: nxt = wel ? ST_ADDR_HI : ST_IGNORE;
                            OP_CERASE:          nxt = wel ? ST_ERASE_ARM : ST_IGNORE;
                            default:            nxt = ST_IGNORE;
                        endcase
                    end
                end
                ST_ADDR_HI: nxt = ST_ADDR_LO;
                ST_ADDR_LO: begin
                    case (cmd_q)
                        OP_READ: begin
                            tx_load = 1'b1;
                            nxt     = ST_READ;
                        end
                        OP_FAST: nxt = ST_DUMMY;
                        OP_PROG: begin
                            buf_clr = 1'b1;
                            nxt     = ST_PROG;
                        end
                        default: nxt = ST_ERASE_ARM;
                    endcase
                end
                ST_DUMMY: begin
                    tx_load = 1'b1;
                    nxt     = ST_READ;
                end
                ST_READ:      tx_load = 1'b1;
                ST_PROG:      buf_we  = 1'b1;
                ST_STATUS: begin
                    tx_load = 1'b1;
                    tx_data = status;
                end
                ST_ERASE_ARM: nxt = ST_ERASE_ARM;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IGNORE;
            endcase
        end
    end

    // command datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_hi <= '0;
            ptr     <= '0;
            pg_off  <= '0;
            pg_cnt  <= '0;
            wel     <= 1'b0;
        end else begin
            if (done) wel <= 1'b0;
            if (sel && byte_stb) begin
                case (state)
                    ST_CMD: begin
                        cmd_q <= rx_byte;
                        if (!busy && rx_byte == OP_WREN) wel <= 1'b1;
                    end
                    ST_ADDR_HI: addr_hi <= rx_byte;
                    ST_ADDR_LO: begin
                        ptr    <= (cmd_q == OP_READ) ? start_ptr + 1'b1 : start_ptr;
                        pg_off <= start_ptr[PAGE_W-1:0];
                        pg_cnt <= '0;
                    end
                    ST_DUMMY, ST_READ: ptr <= ptr + 1'b1;
                    ST_PROG: begin
                        pg_off <= pg_off + 1'b1;
                        if (pg_cnt != CNT_W'(PAGE_BYTES)) pg_cnt <= pg_cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              busy,
    input logic              wel,
    input logic              mem_we,
    input logic              chip_run,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] ptr
);

    // R10: the array is written only inside the busy interval
    p_write_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R11: a commit only ever starts from a select rise
    p_start_on_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    // R9: a commit needs the write-enable latch
    p_start_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R9: the latch is gone once the operation has finished
    p_wel_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !wel);

    // R5: page writes never leave the addressed page
    p_page_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !chip_run) |-> (mem_addr[ADDR_W-1:6] == ptr[ADDR_W-1:6]));

endmodule

bind spi_mem_slave spi_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .busy(busy), .wel(wel),
    .mem_we(mem_we), .chip_run(chip_run), .mem_addr(mem_addr), .ptr(ptr)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int PB    = 150;
    localparam int PBY   = 40;
    localparam int PE    = 600;
    localparam int CE    = 1200;
    localparam int HP    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     m3 = 1'b0;

    logic [7:0] model [DEPTH];
    logic [7:0] dbuf  [128];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_mem_slave #(
        .ADDR_W(AW), .TIMER_W(16), .SYNC_STAGES(2),
        .PROG_BASE_CYC(PB), .PROG_BYTE_CYC(PBY),
        .PAGE_ERASE_CYC(PE), .CHIP_ERASE_CYC(CE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clkw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        sck = m3;
        clkw(HP);
        cs_n = 1'b0;
        clkw(HP);
    endtask

    task automatic sel_off();
        clkw(HP);
        cs_n = 1'b1;
        clkw(4 * HP);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            if (m3) sck = 1'b0;
            mosi = tx[i];
            clkw(HP);
            rx[i] = miso;
            sck = 1'b1;
            clkw(HP);
            if (!m3) sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xfer(b, r);
    endtask

    task automatic wren();
        sel_on(); send(8'h06); sel_off();
    endtask

    task automatic get_status(output logic [7:0] s);
        sel_on(); send(8'h05); xfer(8'h00, s); sel_off();
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        int n;
        n = 0;
        sel_on(); send(8'h05);
        do begin xfer(8'h00, s); n++; end while (s[0] && n < 400);
        sel_off();
        chk(!s[0], "R10", "busy never cleared", s, 0);
    endtask

    task automatic model_prog(input int addr, input int n);
        int base, off;
        base = addr - (addr % 64);
        off  = addr % 64;
        for (int i = 0; i < n; i++) model[base + ((off + i) % 64)] = dbuf[i];
    endtask

    task automatic prog_raw(input logic [15:0] a16, input int n);
        sel_on(); send(8'h02); send(a16[15:8]); send(a16[7:0]);
        for (int i = 0; i < n; i++) send(dbuf[i]);
    endtask

    task automatic read_chk(input int addr, input int n, input bit fast, input string req);
        logic [7:0] r;
        bit ok;
        int bad_i;
        logic [7:0] bad_a, bad_e;
        ok = 1'b1; bad_i = 0; bad_a = 0; bad_e = 0;
        sel_on();
        send(fast ? 8'h0B : 8'h03);
        send(8'(addr >> 8)); send(8'(addr));
        if (fast) send(8'h00);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r);
            if (ok && r !== model[(addr + i) % DEPTH]) begin
                ok = 1'b0; bad_i = i; bad_a = r; bad_e = model[(addr + i) % DEPTH];
            end
        end
        sel_off();
        chk(ok, req, $sformatf("read at %0h+%0d", addr, bad_i), bad_a, bad_e);
    endtask

    task automatic prog_timed(input int addr, input int n, input string req);
        longint t0, t1, tx;
        logic [7:0] s;
        int k;
        for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
        wren();
        prog_raw(16'(addr), n);
        clkw(HP);
        cs_n = 1'b1;
        t0 = cyc;
        clkw(4 * HP);
        model_prog(addr, n);
        sel_on(); send(8'h05);
        k = 0;
        do begin xfer(8'h00, s); k++; end while (s[0] && k < 400);
        t1 = cyc;
        sel_off();
        tx = PB + PBY * n;
        chk((t1 - t0) >= tx && (t1 - t0) <= tx + 3 * 16 * HP, req,
            $sformatf("busy span for %0d bytes", n), t1 - t0, tx);
    endtask

    initial begin
        logic [7:0] s;
        int a, n;
        void'($urandom(32'd7321));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        clkw(10);
        rst_n = 1'b1;
        clkw(10);

        // R8: reset status is zero
        get_status(s);
        chk(s == 8'h00, "R8", "status after reset", s, 8'h00);

        // R8 R9: write enable shows in bit 1
        wren();
        get_status(s);
        chk(s == 8'h02, "R8", "status after write enable", s, 8'h02);

        // R7: chip erase, R9: latch cleared after
        sel_on(); send(8'h60); sel_off();
        wait_ready();
        get_status(s);
        chk(s == 8'h00, "R9", "latch after chip erase", s, 8'h00);
        read_chk(0, 8, 1'b0, "R7");
        read_chk(DEPTH - 8, 8, 1'b0, "R7");

        // R9: program without latch is ignored
        for (int i = 0; i < 4; i++) dbuf[i] = 8'h5A;
        prog_raw(16'h0100, 4); sel_off();
        wait_ready();
        read_chk(16'h0100, 4, 1'b0, "R9");

        // R10 R4 R1: single byte and full page timings
        prog_timed(16'h0005, 1, "R10");
        read_chk(16'h0004, 3, 1'b0, "R4");
        prog_timed(16'h0040, 64, "R10");
        read_chk(16'h0040, 64, 1'b0, "R4");

        // R1: mode 3
        m3 = 1'b1;
        for (int i = 0; i < 5; i++) dbuf[i] = 8'(8'hA0 + i);
        wren(); prog_raw(16'h00A3, 5); sel_off(); model_prog(16'h00A3, 5);
        wait_ready();
        read_chk(16'h00A0, 12, 1'b0, "R1");
        m3 = 1'b0;

        // R5: 70 bytes from offset 60 wrap inside the page
        for (int i = 0; i < 70; i++) dbuf[i] = 8'(i * 3 + 1);
        wren(); prog_raw(16'h013C, 70); sel_off(); model_prog(16'h013C, 70);
        wait_ready();
        read_chk(16'h0100, 64, 1'b0, "R5");

        // R3: fast read
        read_chk(16'h0040, 16, 1'b1, "R3");

        // R2: read wraps top to zero, high address bits ignored
        dbuf[0] = 8'h11; dbuf[1] = 8'h22;
        wren(); prog_raw(16'hFC00 | 16'(DEPTH - 2), 2); sel_off(); model_prog(DEPTH - 2, 2);
        wait_ready();
        read_chk(DEPTH - 2, 4, 1'b0, "R2");

        // R6: page erase
        wren(); sel_on(); send(8'h42); send(8'h00); send(8'h50); sel_off();
        for (int i = 64; i < 128; i++) model[i] = 8'hFF;
        wait_ready();
        read_chk(16'h0040, 64, 1'b0, "R6");
        read_chk(16'h00A0, 12, 1'b0, "R6");

        // R11: select rises mid-byte
        wren();
        for (int i = 0; i < 3; i++) dbuf[i] = 8'h33;
        prog_raw(16'h0200, 3);
        for (int i = 7; i >= 4; i--) begin
            mosi = 1'b1; clkw(HP); sck = 1'b1; clkw(HP); sck = 1'b0;
        end
        sel_off();
        get_status(s);
        chk(s == 8'h02, "R11", "status after abort", s, 8'h02);
        read_chk(16'h0200, 3, 1'b0, "R11");

        // R10: commands ignored while busy
        for (int i = 0; i < 64; i++) dbuf[i] = 8'(8'hC0 ^ i);
        prog_raw(16'h0300, 64); sel_off(); model_prog(16'h0300, 64);
        wren();
        prog_raw(16'h0340, 2); sel_off();
        wait_ready();
        get_status(s);
        chk(s == 8'h00, "R10", "latch after busy write enable", s, 8'h00);
        read_chk(16'h0340, 2, 1'b0, "R10");
        read_chk(16'h0300, 64, 1'b1, "R10");

        // R12: undefined opcode
        wren();
        sel_on(); send(8'hA5); send(8'h00); sel_off();
        get_status(s);
        chk(s == 8'h02, "R12", "status after undefined opcode", s, 8'h02);

        // R4 R5: random programs in either mode
        for (int it = 0; it < 8; it++) begin
            m3 = 1'($urandom);
            a  = int'($urandom % DEPTH);
            n  = 1 + int'($urandom % 70);
            for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
            wren();
            prog_raw(16'(a) | {6'($urandom), 10'h000}, n); sel_off();
            model_prog(a, n);
            wait_ready();
            read_chk(a - (a % 64), 64, 1'($urandom), "R4");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual %0d expected %0d", 195000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule